// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block drives the word address of a synchronous burst memory array. On a rising clock edge it captures an external address when either of two load strobes is taken, and marks the access as valid. After that, the two lowest address bits are produced internally. They step one beat on each cycle in which the advance input is high, so one burst covers four beats. The upper address bits do not change until the next load.

A mode input chooses how the low bits step. In linear order they count up modulo four from the start value. In interleaved order they are the start value XOR the beat number. Three chip-enable inputs decide whether a taken strobe starts an access or ends the current one. The two strobes differ in one way: the processor-side strobe is disregarded while the primary enable is inactive, but the controller-side strobe is always evaluated.

A new address may be loaded on any cycle, including in the middle of a burst, at no cost in cycles. Using the burst stepping is optional.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `access_vld` is 0 and `mem_addr` is all zeros.
- R2: If `strobe_p` is high, `ce_n` is low, `ce2` is high and `ce3_n` is low at a rising edge, then after that edge `mem_addr` equals the sampled `addr_in` and `access_vld` is 1. This also holds when `strobe_c` is high in the same cycle.
- R3: If `strobe_c` is high and the processor strobe is not taken, the same enable condition loads `addr_in` and sets `access_vld` exactly as in R2.
- R4: `strobe_p` has no effect while `ce_n` is high. That cycle behaves as if `strobe_p` were low: an advance still steps the burst, and `strobe_c`, if high, is still evaluated.
- R5: Suppose a strobe is taken while `ce_n` is high, `ce2` is low or `ce3_n` is high. Then `access_vld` goes to 0 after the edge and `mem_addr` keeps its previous value.
- R6: With `linear_mode` = 1, the low two bits of `mem_addr` after n advances are (start + n) mod 4. The upper bits stay at their loaded value for the whole burst.
- R7: With `linear_mode` = 0, the low two bits after n advances are start XOR (n mod 4). A mode input tied to 0 therefore selects interleaved order.
- R8: During an active access, a cycle with `adv` low and no taken strobe leaves both `mem_addr` and `access_vld` unchanged.
- R9: When no access is active, `adv` has no effect: `access_vld` stays 0 and `mem_addr` does not change.
- R10: After four advances, the beat count wraps and the low bits return to the start value, in either order.
- R11: A load in the middle of a burst restarts at the new address with the beat count at zero. No idle cycle is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External start address |
| strobe_p | input | 1 | Processor-side load strobe, active high, takes priority |
| strobe_c | input | 1 | Controller-side load strobe, active high |
| adv | input | 1 | Advance the burst by one beat |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Tertiary chip enable, active low |
| linear_mode | input | 1 | 1 = linear order, 0 = interleaved order |
| mem_addr | output | ADDR_W | Current address to the array |
| access_vld | output | 1 | Current address belongs to a live access |

## Verification
The assertions check the following on every cycle:
- what a load leaves behind on the outputs;
- that a strobe seen with a failed enable ends the access;
- that outputs hold when neither a strobe nor an advance is present;
- that a disregarded processor strobe changes nothing;
- that idle advances are inert;
- that each linear step adds one modulo four while the upper bits stay put.

Some behaviour depends on the start value and the beat history, so only the bench's scenarios show it:
- the interleaved XOR sequence;
- the wrap back to the start after four beats;
- the restart on a reload in the middle of a burst.

// File: rtl/bas_pkg.sv
`timescale 1ns/1ps
// Shared types of the burst address sequencer.
// Assumes: the burst order bit follows the mode pin (1 = linear).
package bas_pkg;
    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DESEL = 2'd2,
        ACT_STEP  = 2'd3
    } seq_act_e;
endpackage

// File: rtl/bas_start_ctl.sv
`timescale 1ns/1ps
// Decides the action of the current cycle from the strobes, the enables
// and the advance input.
// Assumes: the processor strobe is disregarded while ce_n is high; when it
// is taken, the controller strobe does not matter.
module bas_start_ctl
    import bas_pkg::*;
(
    input  logic     strobe_p,
    input  logic     strobe_c,
    input  logic     adv,
    input  logic     ce_n,
    input  logic     ce2,
    input  logic     ce3_n,
    input  logic     active,
    output seq_act_e act
);
    logic enables_ok;
    logic p_taken;

    // Purpose: qualify the enables and pick a load, a deselect, a step or a hold.
    always_comb begin
        enables_ok = !ce_n && ce2 && !ce3_n;
        p_taken    = strobe_p && !ce_n;
        if (p_taken || strobe_c) begin
            act = enables_ok ? ACT_LOAD : ACT_DESEL;
        end else if (adv && active) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end
endmodule

// File: rtl/bas_beat_ctr.sv
`timescale 1ns/1ps
// Holds the start low bits and the beat count, and forms the low address
// bits in linear or interleaved order.
// Assumes: the order input is steady for the length of a burst.
module bas_beat_ctr
    import bas_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_e         act,
    input  logic [LOW_W-1:0] low_in,
    input  burst_order_e     order,
    output logic [LOW_W-1:0] low_out
);
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] ilv_low;

    // Purpose: capture the start on a load, count beats on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (act == ACT_LOAD) begin
            start_q <= low_in;
            beat_q  <= '0;
        end else if (act == ACT_STEP) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // Interleaved order: each low bit is the start bit flipped by the beat bit.
    for (genvar i = 0; i < LOW_W; i++) begin : g_ilv
        assign ilv_low[i] = start_q[i] ^ beat_q[i];
    end

    // Purpose: linear order wraps inside the aligned group.
    always_comb lin_low = start_q + beat_q;

    // Purpose: choose the order the mode asks for.
    always_comb low_out = (order == ORD_LINEAR) ? lin_low : ilv_low;
endmodule

// File: rtl/bas_addr_reg.sv
`timescale 1ns/1ps
// Holds the upper address bits and the access-valid flag.
// Assumes: the upper bits change only on a load.
module bas_addr_reg
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2,
    localparam int UP_W  = ADDR_W - LOW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_act_e        act,
    input  logic [UP_W-1:0] up_in,
    output logic [UP_W-1:0] up_out,
    output logic            active
);
    // Purpose: load the upper bits and start or end an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_out <= '0;
            active <= 1'b0;
        end else if (act == ACT_LOAD) begin
            up_out <= up_in;
            active <= 1'b1;
        end else if (act == ACT_DESEL) begin
            active <= 1'b0;
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
// Top of the burst address sequencer. It loads an address on either strobe,
// steps the low bits on each advance and flags valid accesses.
// Assumes: all inputs are synchronous to clk; linear_mode is held steady
// within a burst.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_p,
    input  logic              strobe_c,
    input  logic              adv,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              linear_mode,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              access_vld
);
    localparam int UP_W = ADDR_W - LOW_W;

    seq_act_e         act;
    logic [UP_W-1:0]  up_q;
    logic [LOW_W-1:0] low_q;
    burst_order_e     order;

    // Purpose: map the mode pin onto the order type.
    always_comb order = burst_order_e'(linear_mode);

    bas_start_ctl u_ctl (
        .strobe_p (strobe_p),
        .strobe_c (strobe_c),
        .adv      (adv),
        .ce_n     (ce_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .active   (access_vld),
        .act      (act)
    );

    bas_beat_ctr #(.LOW_W(LOW_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .low_in  (addr_in[LOW_W-1:0]),
        .order   (order),
        .low_out (low_q)
    );

    bas_addr_reg #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_areg (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .up_in  (addr_in[ADDR_W-1:LOW_W]),
        .up_out (up_q),
        .active (access_vld)
    );

    // Purpose: join the upper and low parts into the array address.
    always_comb mem_addr = {up_q, low_q};
endmodule

// File: rtl/bas_checker.sv
`timescale 1ns/1ps
// Property checker for burst_addr_seq. It sees only the ports and is
// attached by bind.
module bas_checker #(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_p,
    input logic              strobe_c,
    input logic              adv,
    input logic              ce_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              linear_mode,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              access_vld
);
    logic en_ok;
    logic p_eff;
    logic any_ld;

    // Purpose: decode port-level conditions used by the properties.
    always_comb begin
        en_ok  = !ce_n && ce2 && !ce3_n;
        p_eff  = strobe_p && !ce_n;
        any_ld = p_eff || strobe_c;
    end

    p_load_p_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_eff && en_ok) |=> (access_vld && mem_addr == $past(addr_in)));

    p_load_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_eff && strobe_c && en_ok) |=> (access_vld && mem_addr == $past(addr_in)));

    p_ignore_p_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_p && ce_n && !strobe_c && !adv && $stable(linear_mode))
        |=> ($stable(access_vld) && (!$stable(linear_mode) || $stable(mem_addr))));

    p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ld && !en_ok) |=> (!access_vld && $stable(mem_addr)));

    p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (access_vld && adv && !any_ld && linear_mode)
        |=> (!linear_mode || (mem_addr[LOW_W-1:0] ==
             LOW_W'($past(mem_addr[LOW_W-1:0]) + 1'b1))));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ld) |=> $stable(mem_addr[ADDR_W-1:LOW_W]));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (access_vld && !adv && !any_ld)
        |=> (access_vld && (!$stable(linear_mode) || $stable(mem_addr))));

    p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_vld && !any_ld)
        |=> (!access_vld && (!$stable(linear_mode) || $stable(mem_addr))));
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_p = 1'b0, strobe_c = 1'b0, adv = 1'b0;
    logic          ce_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, linear_mode = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          access_vld;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_act = 0, m_up = 0, m_start = 0, m_beat = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .LOW_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_p(strobe_p),
        .strobe_c(strobe_c), .adv(adv), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
        .linear_mode(linear_mode), .mem_addr(mem_addr), .access_vld(access_vld)
    );

    function automatic logic [AW-1:0] exp_addr();
        int low;
        low = linear_mode ? ((m_start + m_beat) % 4) : (m_start ^ m_beat);
        return AW'(m_up * 4 + low);
    endfunction

    task automatic compare(input string tag);
        logic [AW-1:0] ea;
        logic          ev;
        ea = exp_addr();
        ev = (m_act != 0);
        checks++;
        if (access_vld !== ev || mem_addr !== ea) begin
            errors++;
            $display("FAIL %s: vld=%0b addr=%h expected vld=%0b addr=%h",
                     tag, access_vld, mem_addr, ev, ea);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, compare at next negedge.
    task automatic cyc(input logic sp, input logic sc, input logic av,
                       input logic cen, input logic c2, input logic c3n,
                       input logic md, input logic [AW-1:0] a, input string tag);
        bit en, pt;
        strobe_p = sp; strobe_c = sc; adv = av; ce_n = cen; ce2 = c2;
        ce3_n = c3n; linear_mode = md; addr_in = a;
        @(posedge clk);
        en = !cen && c2 && !c3n;
        pt = sp && !cen;
        if (pt || sc) begin
            if (en) begin
                m_act = 1; m_up = int'(a >> 2); m_start = int'(a & 3); m_beat = 0;
            end else begin
                m_act = 0;
            end
        end else if (av && m_act != 0) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // R2 + R6 + R10: linear burst from low bits 2, four advances wrap
        cyc(1, 0, 0, 0, 1, 0, 1, 20'h12346, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 1, 0, 1, 20'h0, (i == 3) ? "R10" : "R6");

        // R3 + R7 + R10: interleaved burst started by the controller strobe
        cyc(0, 1, 0, 0, 1, 0, 0, 20'hABCD1, "R3");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 1, 0, 0, 20'h0, (i == 3) ? "R10" : "R7");
        cyc(0, 1, 0, 0, 1, 0, 0, 20'h55553, "R3");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 1, 0, 0, 20'h0, "R7");

        // R8: pauses inside a burst
        cyc(0, 0, 0, 0, 1, 0, 0, 20'h0, "R8");
        cyc(0, 0, 0, 1, 0, 1, 0, 20'hFFFFF, "R8");
        cyc(0, 0, 1, 0, 1, 0, 0, 20'h0, "R7");

        // R4: processor strobe disregarded while ce_n is high; advance still steps
        cyc(0, 1, 0, 0, 1, 0, 1, 20'h00100, "R3");
        cyc(1, 0, 1, 1, 1, 0, 1, 20'h77777, "R4");
        cyc(1, 0, 0, 1, 1, 0, 1, 20'h77777, "R4");
        // R4 + R5: controller strobe still evaluated and deselects
        cyc(1, 1, 0, 1, 1, 0, 1, 20'h77777, "R4");

        // R9: advances while idle do nothing
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 1, 0, 1, 20'h0, "R9");

        // R5: ce2 low on a controller strobe, ce3_n high on a processor strobe
        cyc(1, 0, 0, 0, 1, 0, 0, 20'h3C3C2, "R2");
        cyc(0, 0, 1, 0, 1, 0, 0, 20'h0, "R7");
        cyc(0, 1, 0, 0, 0, 0, 0, 20'h11111, "R5");
        cyc(1, 0, 0, 0, 1, 0, 0, 20'h22220, "R2");
        cyc(1, 0, 0, 0, 1, 1, 0, 20'h44444, "R5");
        cyc(0, 0, 1, 0, 1, 0, 0, 20'h0, "R9");

        // R11: reload in the middle of a burst, back to back
        cyc(1, 0, 0, 0, 1, 0, 1, 20'h0A0A1, "R2");
        cyc(0, 0, 1, 0, 1, 0, 1, 20'h0, "R6");
        cyc(0, 1, 1, 0, 1, 0, 1, 20'h0B0B3, "R11");
        cyc(1, 0, 1, 0, 1, 0, 1, 20'h0C0C2, "R11");
        cyc(0, 0, 1, 0, 1, 0, 1, 20'h0, "R6");

        // R2: both strobes together load once
        cyc(1, 1, 0, 0, 1, 0, 0, 20'hDEAD2, "R2");
        cyc(0, 0, 1, 0, 1, 0, 0, 20'h0, "R7");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule